// File: doc/BRIEF.md
# Programmable Power-of-Two Tick Divider

This block counts timing ticks in a 24-stage binary counter. It raises a terminal-count strobe when a chosen stage rolls over, so the delay it measures is a power of two between 2 and 2^24 ticks. The delay in time is the division ratio divided by the tick rate. Surrounding trigger logic clears the counter when a delay starts or restarts. It then feeds ticks and waits for the strobe that ends the delay.

A 4-bit select picks the ratio. The top select bit chooses between two ranges. In the short range the ratio is 2^(low bits + 1). In the long range it is 2^(low bits + 17). Ratios 2^9 to 2^16 cannot be selected. While the top select bit is low, the 24 stages work as three independent 8-bit sections that all advance on the same tick. This makes a fast full-chain test possible. Select 0111 and apply 255 ticks to fill every stage with ones. Then switch to any long-range code, and one more tick carries a zero through all 24 stages and fires the strobe.

Top module: `pow2_divider`

## Requirements
- R1: While rst_n is low, tc is 0 at once and all stages are zero; after release the first tc comes after exactly the selected ratio of accepted ticks.
- R2: With sel[3]=0, tc pulses after every 2^(sel[2:0]+1) accepted ticks. tc is registered: it is high for the clock cycle after the edge that accepts the tick on which stage sel[2:0] of the low section goes from 1 to 0.
- R3: With sel[3]=1, the 24 stages form one binary chain, and tc pulses after every 2^(sel[2:0]+17) accepted ticks (stage sel[2:0]+16 going from 1 to 0).
- R4: With sel[3]=0, each of the three 8-bit sections advances by one on every accepted tick, and no carry passes between sections.
- R5: tc is never high for two clock cycles in a row.
- R6: clr is synchronous and overrides tick_en. At the next edge it zeroes all stages, and tc is 0 in the following cycle.
- R7: While tick_en and clr are both low, the stages hold their value and tc stays 0.
- R8: After clr, sel=0111 and 255 ticks, switching to any sel with sel[3]=1 and applying one tick produces tc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Advance the counter on this edge |
| clr | input | 1 | Synchronous clear of all stages, wins over tick_en |
| sel | input | 4 | Ratio select; bit 3 picks the short or long range |
| tc | output | 1 | One-cycle terminal-count strobe |

## Verification
The hardest case to reach from the ports is a rollover of the upper stages. A long-range code only fires after 131072 or more ticks, and nothing inside the counter is visible. The bench reaches it through the split-mode fill: 255 ticks load all ones, and a switch to each long-range code follows. One full 2^17-tick run pins down the exact count for the lowest long-range stage. A bench model of the counter, driven by seeded random ticks, clears and select changes, predicts tc on every cycle.

// File: rtl/p2div_pkg.sv
package p2div_pkg;
  typedef enum logic {
    MODE_SPLIT = 1'b0,
    MODE_CHAIN = 1'b1
  } div_mode_e;

  localparam int DEF_SECT_W = 8;
  localparam int DEF_NSECT  = 3;
  localparam int DEF_SEL_W  = 4;
endpackage

// File: rtl/p2div_section.sv
module p2div_section #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val <= '0;
    else if (clr) val <= '0;
    else if (inc) val <= val + 1'b1;
  end

  assign full = &val;

  // R4: a section told to advance moves up by exactly one
  assert_section_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (val == W'($past(val) + 1'b1)));

  // R6: clear empties the section
  assert_section_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (val == '0));
endmodule

// File: rtl/p2div_tap.sv
module p2div_tap #(
  parameter int CNT_W = 24,
  parameter int SEL_W = 4
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  localparam int LOW_N   = 2 ** (SEL_W - 1);
  localparam int HI_BASE = CNT_W - LOW_N;
  localparam int IDX_W   = $clog2(CNT_W);

  logic [CNT_W-1:0] pfx;
  logic [IDX_W-1:0] idx;

  // pfx[j]: stages 0..j all ones, so the next tick clears stage j
  always_comb begin
    logic acc;
    acc = 1'b1;
    for (int j = 0; j < CNT_W; j++) begin
      acc    = acc & cnt[j];
      pfx[j] = acc;
    end
  end

  always_comb begin
    if (sel[SEL_W-1]) idx = IDX_W'(HI_BASE) + IDX_W'(sel[SEL_W-2:0]);
    else              idx = IDX_W'(sel[SEL_W-2:0]);
  end

  assign hit = pfx[idx];
endmodule

// File: rtl/pow2_divider.sv
module pow2_divider
  import p2div_pkg::*;
#(
  parameter int SECT_W = DEF_SECT_W,
  parameter int NSECT  = DEF_NSECT,
  parameter int SEL_W  = DEF_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tc
);
  localparam int CNT_W = SECT_W * NSECT;

  div_mode_e               mode;
  logic [NSECT:0]          carry;
  logic [NSECT-1:0]        inc;
  logic [NSECT-1:0]        sfull;
  logic [NSECT-1:0][SECT_W-1:0] sval;
  logic [CNT_W-1:0]        cnt;
  logic                    hit;

  assign mode = sel[SEL_W-1] ? MODE_CHAIN : MODE_SPLIT;
  assign cnt  = sval;

  always_comb begin
    carry[0] = tick_en;
    for (int i = 0; i < NSECT; i++) carry[i+1] = carry[i] & sfull[i];
  end

  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    assign inc[g] = (mode == MODE_SPLIT) ? tick_en : carry[g];
    p2div_section #(.W(SECT_W)) u_sect (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .inc  (inc[g]),
      .val  (sval[g]),
      .full (sfull[g])
    );
  end

  p2div_tap #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_tap (
    .cnt(cnt),
    .sel(sel),
    .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc <= 1'b0;
    else        tc <= tick_en && !clr && hit;
  end

  // R5: strobe is a single cycle
  assert_tc_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);

  // R6: clear zeroes the chain and suppresses the strobe
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!tc && cnt == '0));

  // R7: no tick, no change
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr) |=> ($stable(cnt) && !tc));

  // R3: long range counts as one binary chain
  assert_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !clr && mode == MODE_CHAIN) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: tb/tb_pow2_divider.sv
module tb_pow2_divider;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       clr = 1'b0;
  logic [3:0] sel = 4'b0000;
  logic       tc;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [23:0] m = '0;
  logic prev_tc = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pow2_divider dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .clr(clr), .sel(sel), .tc(tc)
  );

  function automatic int ratio_of(input logic [3:0] s);
    return s[3] ? (1 << (int'(s[2:0]) + 17)) : (1 << (int'(s[2:0]) + 1));
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: tc actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic t, input logic c, input logic [3:0] s, input string tag);
    logic [23:0] nm;
    int idx;
    logic expt;
    tick_en = t; clr = c; sel = s;
    @(posedge clk);
    expt = 1'b0;
    if (c) m = '0;
    else if (t) begin
      nm  = s[3] ? 24'(m + 1) : {m[23:16] + 8'd1, m[15:8] + 8'd1, m[7:0] + 8'd1};
      idx = s[3] ? 16 + int'(s[2:0]) : int'(s[2:0]);
      expt = m[idx] & ~nm[idx];
      m = nm;
    end
    @(negedge clk);
    check(tc, expt, tag);
    total++;
    if (prev_tc && tc) begin
      bad++;
      $display("FAIL R5: tc actual=1 expected=0 on consecutive cycles at %0t", $time);
    end
    prev_tc = tc;
  endtask

  // count ticks to the first strobe and compare to the ratio formula
  task automatic first_tc(input logic [3:0] s, input string tag);
    int n;
    n = 0;
    step(1'b0, 1'b1, s, "R6");
    do begin
      step(1'b1, 1'b0, s, tag);
      n++;
    end while (!tc && n < ratio_of(s) + 2);
    total++;
    if (n != ratio_of(s)) begin
      bad++;
      $display("FAIL %s: ticks to tc actual=%0d expected=%0d (sel=%b)", tag, n, ratio_of(s), s);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check(tc, 1'b0, "R1");
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(tc, 1'b0, "R1");

    // R1: first strobe after reset release with no clear
    begin
      int n;
      n = 0;
      do begin step(1'b1, 1'b0, 4'b0001, "R1"); n++; end while (!tc && n < 10);
      total++;
      if (n != 4) begin bad++; $display("FAIL R1: ticks actual=%0d expected=4", n); end
    end

    // R2: every short-range code, two periods each
    for (int k = 0; k < 8; k++) begin
      first_tc(4'(k), "R2");
      for (int i = 0; i < ratio_of(4'(k)); i++) step(1'b1, 1'b0, 4'(k), "R2");
    end

    // R7: idle cycles interleaved with ticks
    step(1'b0, 1'b1, 4'b0010, "R6");
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b0, 4'b0010, "R7");
      step(1'b0, 1'b0, 4'b0010, "R7");
      step(1'b0, 1'b0, 4'b0010, "R7");
    end

    // R6: clear with tick_en high mid-count, then a full period
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 4'b0011, "R6");
    step(1'b1, 1'b1, 4'b0011, "R6");
    first_tc(4'b0011, "R6");

    // R8 and R4: split fill then one chained tick for every long code
    for (int k = 0; k < 8; k++) begin
      step(1'b0, 1'b1, 4'b0111, "R6");
      for (int i = 0; i < 255; i++) step(1'b1, 1'b0, 4'b0111, "R4");
      step(1'b1, 1'b0, {1'b1, 3'(k)}, "R8");
      total++;
      if (tc !== 1'b1) begin bad++; $display("FAIL R8: tc actual=%0b expected=1 (k=%0d)", tc, k); end
    end

    // R4: split fill with short code 0 pulses every two ticks, sections all full
    step(1'b0, 1'b1, 4'b0000, "R6");
    for (int i = 0; i < 255; i++) step(1'b1, 1'b0, 4'b0000, "R4");
    step(1'b1, 1'b0, 4'b1000, "R4");

    // R3: exact long-range count for the lowest long code
    first_tc(4'b1000, "R3");

    // random stimulus against the model
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] s;
      logic t, c;
      s = 4'($urandom_range(0, 15));
      if (s[3] && ($urandom_range(0, 3) != 0)) s[3] = 1'b0;
      t = ($urandom_range(0, 3) != 0);
      c = ($urandom_range(0, 63) == 0);
      step(t, c, s, "R5");
    end

    // R1: async reset while tc is high
    step(1'b0, 1'b1, 4'b0000, "R6");
    step(1'b1, 1'b0, 4'b0000, "R1");
    step(1'b1, 1'b0, 4'b0000, "R1");
    rst_n = 1'b0;
    tick_en = 1'b0;
    m = '0;
    #1;
    check(tc, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    prev_tc = 1'b0;
    begin
      int n;
      n = 0;
      do begin step(1'b1, 1'b0, 4'b0010, "R1"); n++; end while (!tc && n < 20);
      total++;
      if (n != 8) begin bad++; $display("FAIL R1: ticks after reset actual=%0d expected=8", n); end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule